// File: doc/BRIEF.md
# Conditional Skip Evaluator

This unit resolves the conditional skip instructions of a processor with 16-bit instruction words. Four families are handled: a skip when two registers hold equal values, a skip on a clear or set bit of a register, and a skip on a clear or set bit of an I/O port. When an instruction word arrives with its start strobe, the unit decodes the operand fields. In the same cycle it issues one or two read requests to the external data space. For an I/O port it turns the 5-bit port number into a data address by adding a fixed base.

One cycle later the read data returns and the unit evaluates the skip condition. When the condition holds, the unit looks at the program word that follows the skip instruction, which arrives together with the instruction. That word is pre-classified as one word long, two words long, or undecodable. From this the unit works out how many words the program counter must jump over. It also gives the extra cycle cost, or raises an invalid-instruction flag when the following word cannot be decoded.

The result is presented for exactly one cycle on a valid strobe. The pipeline accepts one instruction per cycle.

Top module: `skip_eval`

## Requirements
- R1: Words matching 0001 00xx xxxx xxxx are register-equality skips. Port A reads the register number in bits 8:4. Port B reads the register number formed by bit 9 as MSB above bits 3:0. The skip is taken when both values are equal. Only this family enables port B.
- R2: Words matching 1111 110x xxxx xxxx skip when bit b of register r is 0. Words matching 1111 111x xxxx xxxx skip when that bit is 1. Here r is bits 8:4, sent on port A, and b is bits 2:0.
- R3: Words with upper byte 0x99 skip when bit b of I/O port p is 0. Words with upper byte 0x9B skip when that bit is 1. Here p is bits 7:3 and b is bits 2:0. The read address on port A is p plus IO_BASE, which is 0x20 by default.
- R4: A taken skip reports 2 words when the following word is two words long, and 1 word otherwise. Under mask 0xFE0E, two-word forms compare equal to 0x940C or 0x940E. Under mask 0xFE0F, two-word forms compare equal to 0x9000 or 0x9200.
- R5: The extra-cycle output is 1 on a taken skip and 0 when the condition is false. A false condition reports 0 words.
- R6: The following word 0xFFFF is undecodable. With a true condition it raises the invalid flag and reports 0 words and 0 extra cycles. With a false condition no invalid flag is raised.
- R7: The read enables and addresses depend combinationally on the instruction in its start cycle. The result is valid for one cycle, after the second rising edge following the start cycle. Back-to-back starts each produce their own result.
- R8: A start with any other instruction word issues no read and produces no valid strobe.
- R9: After synchronous reset, no result is valid and all result outputs are 0.
- R10: Whenever the valid strobe is low, the word count, extra-cycle and invalid outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction word presented this cycle |
| instr | input | 16 | Instruction word under evaluation |
| next_word | input | 16 | Program word following the instruction |
| rd_a_en | output | 1 | Read request, port A |
| rd_a_addr | output | DADDR_W | Data-space address, port A |
| rd_b_en | output | 1 | Read request, port B |
| rd_b_addr | output | DADDR_W | Data-space address, port B |
| rd_a_data | input | DATA_W | Port A data, one cycle after the request |
| rd_b_data | input | DATA_W | Port B data, one cycle after the request |
| res_valid | output | 1 | One-cycle result strobe |
| res_words | output | 2 | Words to jump over beyond the skip instruction |
| res_extra | output | 1 | Extra cycle consumed |
| res_invalid | output | 1 | Following word undecodable while skipping |

## Verification
The bench builds the block with its defaults: DADDR_W of 8, DATA_W of 8 and IO_BASE of 0x20. A 256-entry data model therefore covers both the register window and the whole I/O window. That includes port 31, which maps to the top address 0x3F, and every bit position from 0 to 7. The chosen following words include the two-word forms, a word that differs from them only in their don't-care bits, near-miss single-word encodings, and the undecodable word.

// File: rtl/skip_eval_pkg.sv
package skip_eval_pkg;

    typedef enum logic [2:0] {
        SK_NONE,
        SK_EQ,
        SK_RBIT0,
        SK_RBIT1,
        SK_IOBIT0,
        SK_IOBIT1
    } skip_kind_e;

    typedef enum logic [1:0] {
        NW_ONE,
        NW_TWO,
        NW_BAD
    } next_len_e;

    typedef struct packed {
        skip_kind_e kind;
        logic [2:0] bsel;
        next_len_e  nlen;
    } pend_t;

    localparam logic [15:0] UNDECODABLE_WORD = 16'hFFFF;

    function automatic skip_kind_e decode_kind(input logic [15:0] w);
        skip_kind_e k;
        k = SK_NONE;
        if (w[15:10] == 6'b000100)      k = SK_EQ;
        else if (w[15:9] == 7'b1111110) k = SK_RBIT0;
        else if (w[15:9] == 7'b1111111) k = SK_RBIT1;
        else if (w[15:8] == 8'h99)      k = SK_IOBIT0;
        else if (w[15:8] == 8'h9B)      k = SK_IOBIT1;
        return k;
    endfunction

    function automatic next_len_e classify_next(input logic [15:0] w);
        next_len_e n;
        n = NW_ONE;
        if (w == UNDECODABLE_WORD)
            n = NW_BAD;
        else if ((w & 16'hFE0E) == 16'h940C || (w & 16'hFE0E) == 16'h940E)
            n = NW_TWO;
        else if ((w & 16'hFE0F) == 16'h9000 || (w & 16'hFE0F) == 16'h9200)
            n = NW_TWO;
        return n;
    endfunction

endpackage

// File: rtl/skip_decode.sv
module skip_decode
    import skip_eval_pkg::*;
#(
    parameter int DADDR_W = 8,
    parameter int IO_BASE = 32
) (
    input  logic [15:0]        instr,
    output skip_kind_e         kind,
    output logic [2:0]         bsel,
    output logic               uses_b,
    output logic [DADDR_W-1:0] a_addr,
    output logic [DADDR_W-1:0] b_addr
);
    always_comb begin
        kind   = decode_kind(instr);
        bsel   = instr[2:0];
        uses_b = (kind == SK_EQ);
        b_addr = DADDR_W'({instr[9], instr[3:0]});
        if (kind == SK_IOBIT0 || kind == SK_IOBIT1)
            a_addr = DADDR_W'(instr[7:3]) + DADDR_W'(IO_BASE);
        else
            a_addr = DADDR_W'(instr[8:4]);
    end
endmodule

// File: rtl/skip_next_len.sv
module skip_next_len
    import skip_eval_pkg::*;
(
    input  logic [15:0] word,
    output next_len_e   nlen
);
    always_comb nlen = classify_next(word);
endmodule

// File: rtl/skip_resolve.sv
module skip_resolve
    import skip_eval_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_v,
    input  pend_t             pend,
    input  logic [DATA_W-1:0] a_data,
    input  logic [DATA_W-1:0] b_data,
    output logic              res_valid,
    output logic [1:0]        res_words,
    output logic              res_extra,
    output logic              res_invalid
);
    logic cond;

    always_comb begin
        case (pend.kind)
            SK_EQ:                cond = (a_data == b_data);
            SK_RBIT0, SK_IOBIT0:  cond = ~a_data[pend.bsel];
            SK_RBIT1, SK_IOBIT1:  cond = a_data[pend.bsel];
            default:              cond = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_words   <= 2'd0;
            res_extra   <= 1'b0;
            res_invalid <= 1'b0;
        end else begin
            res_valid   <= pend_v;
            res_words   <= 2'd0;
            res_extra   <= 1'b0;
            res_invalid <= 1'b0;
            if (pend_v && cond) begin
                if (pend.nlen == NW_BAD) begin
                    res_invalid <= 1'b1;
                end else begin
                    res_words <= (pend.nlen == NW_TWO) ? 2'd2 : 2'd1;
                    res_extra <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
    import skip_eval_pkg::*;
#(
    parameter int DADDR_W = 8,
    parameter int DATA_W  = 8,
    parameter int IO_BASE = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [15:0]        instr,
    input  logic [15:0]        next_word,
    output logic               rd_a_en,
    output logic [DADDR_W-1:0] rd_a_addr,
    output logic               rd_b_en,
    output logic [DADDR_W-1:0] rd_b_addr,
    input  logic [DATA_W-1:0]  rd_a_data,
    input  logic [DATA_W-1:0]  rd_b_data,
    output logic               res_valid,
    output logic [1:0]         res_words,
    output logic               res_extra,
    output logic               res_invalid
);
    skip_kind_e kind;
    logic [2:0] bsel;
    logic       uses_b;
    next_len_e  nlen;
    pend_t      pend_q;
    logic       pend_v_q;

    skip_decode #(.DADDR_W(DADDR_W), .IO_BASE(IO_BASE)) u_dec (
        .instr  (instr),
        .kind   (kind),
        .bsel   (bsel),
        .uses_b (uses_b),
        .a_addr (rd_a_addr),
        .b_addr (rd_b_addr)
    );

    skip_next_len u_len (
        .word (next_word),
        .nlen (nlen)
    );

    assign rd_a_en = start && (kind != SK_NONE);
    assign rd_b_en = start && uses_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v_q <= 1'b0;
            pend_q   <= '{kind: SK_NONE, bsel: 3'd0, nlen: NW_ONE};
        end else begin
            pend_v_q <= rd_a_en;
            pend_q   <= '{kind: kind, bsel: bsel, nlen: nlen};
        end
    end

    skip_resolve #(.DATA_W(DATA_W)) u_res (
        .clk         (clk),
        .rst         (rst),
        .pend_v      (pend_v_q),
        .pend        (pend_q),
        .a_data      (rd_a_data),
        .b_data      (rd_b_data),
        .res_valid   (res_valid),
        .res_words   (res_words),
        .res_extra   (res_extra),
        .res_invalid (res_invalid)
    );
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
    parameter int DADDR_W = 8,
    parameter int DATA_W  = 8,
    parameter int IO_BASE = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [15:0]        instr,
    input logic [15:0]        next_word,
    input logic               rd_a_en,
    input logic [DADDR_W-1:0] rd_a_addr,
    input logic               rd_b_en,
    input logic [DADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0]  rd_a_data,
    input logic [DATA_W-1:0]  rd_b_data,
    input logic               res_valid,
    input logic [1:0]         res_words,
    input logic               res_extra,
    input logic               res_invalid
);
    p_b_port_eq_only_r1: assert property (@(posedge clk) disable iff (rst)
        rd_b_en |-> (rd_a_en && instr[15:10] == 6'b000100));

    p_io_window_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_a_en && instr[15:12] == 4'h9) |-> (rd_a_addr >= DADDR_W'(IO_BASE)));

    p_words_range_r4: assert property (@(posedge clk) disable iff (rst)
        res_words != 2'd3);

    p_extra_tracks_skip_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_extra == (res_words != 2'd0)));

    p_invalid_no_skip_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_invalid) |-> (res_words == 2'd0 && !res_extra));

    p_result_latency_r7: assert property (@(posedge clk) disable iff (rst)
        rd_a_en |=> ##1 res_valid);

    p_no_read_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !start |-> (!rd_a_en && !rd_b_en));

    p_quiet_outputs_r10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (res_words == 2'd0 && !res_extra && !res_invalid));
endmodule

bind skip_eval skip_eval_chk #(.DADDR_W(DADDR_W), .DATA_W(DATA_W), .IO_BASE(IO_BASE)) u_chk (.*);

// File: tb/sim_skip_eval.sv
module sim_skip_eval;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [15:0] next_word = 16'h0000;
    logic        rd_a_en, rd_b_en;
    logic [7:0]  rd_a_addr, rd_b_addr;
    logic [7:0]  a_q = 8'h00, b_q = 8'h00;
    logic        res_valid, res_extra, res_invalid;
    logic [1:0]  res_words;
    logic [7:0]  mem [256];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    skip_eval u0 (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .next_word(next_word),
        .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr),
        .rd_a_data(a_q), .rd_b_data(b_q),
        .res_valid(res_valid), .res_words(res_words), .res_extra(res_extra),
        .res_invalid(res_invalid)
    );

    always @(posedge clk) begin
        if (rd_a_en) a_q <= mem[rd_a_addr];
        if (rd_b_en) b_q <= mem[rd_b_addr];
    end

    function automatic logic [15:0] enc_eq(input logic [4:0] d, input logic [4:0] r);
        return {6'b000100, r[4], d, r[3:0]};
    endfunction
    function automatic logic [15:0] enc_rbit(input bit set, input logic [4:0] r, input logic [2:0] b);
        return {6'b111111, set, r, 1'b0, b};
    endfunction
    function automatic logic [15:0] enc_io(input bit set, input logic [4:0] p, input logic [2:0] b);
        return {8'h99 | (set ? 8'h02 : 8'h00), p, b};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One instruction through the pipe; checks the read request and the result.
    task automatic run_one(input string tag, input logic [15:0] ins, input logic [15:0] nw,
                           input int exp_a, input bit exp_ben, input int exp_b,
                           input int exp_words, input int exp_extra, input int exp_inv);
        @(negedge clk);
        instr = ins; next_word = nw; start = 1'b1;
        #1;
        chk({tag, " R7 rd_a_en"}, rd_a_en, 1);
        chk({tag, " R1/R2/R3 addr A"}, rd_a_addr, exp_a);
        chk({tag, " R1 rd_b_en"}, rd_b_en, exp_ben);
        if (exp_ben) chk({tag, " R1 addr B"}, rd_b_addr, exp_b);
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R7 not yet valid"}, res_valid, 0);
        @(negedge clk);
        chk({tag, " R7 valid"}, res_valid, 1);
        chk({tag, " R4 words"}, res_words, exp_words);
        chk({tag, " R5 extra"}, res_extra, exp_extra);
        chk({tag, " R6 invalid"}, res_invalid, exp_inv);
        @(negedge clk);
        chk({tag, " R7 single strobe"}, res_valid, 0);
        chk({tag, " R10 quiet"}, {res_words, res_extra, res_invalid}, 0);
    endtask

    task automatic t_non_skip_r8();
        @(negedge clk);
        instr = 16'h0C00; next_word = 16'h0000; start = 1'b1;
        #1;
        chk("R8 no read A", rd_a_en, 0);
        chk("R8 no read B", rd_b_en, 0);
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R8 no strobe", res_valid, 0);
        @(negedge clk);
        chk("R8 no strobe later", res_valid, 0);
    endtask

    task automatic t_back_to_back_r7();
        @(negedge clk);
        instr = enc_rbit(0, 5'd7, 3'd0); next_word = 16'h940C; start = 1'b1;
        @(negedge clk);
        instr = enc_eq(5'd3, 5'd7); next_word = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        chk("R7 b2b first valid", res_valid, 1);
        chk("R7 b2b first words", res_words, 2);
        @(negedge clk);
        chk("R7 b2b second valid", res_valid, 1);
        chk("R7 b2b second words", res_words, 0);
        chk("R7 b2b second extra", res_extra, 0);
        @(negedge clk);
        chk("R7 b2b drained", res_valid, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[3]    = 8'h55;
        mem[20]   = 8'h55;
        mem[7]    = 8'h5A;
        mem[8'h25] = 8'h81;
        mem[8'h3F] = 8'h40;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", res_valid, 0);
        chk("R9 reset outputs", {res_words, res_extra, res_invalid}, 0);
        rst = 1'b0;
        @(negedge clk);

        run_one("R1 eq taken",         enc_eq(5'd3, 5'd20),        16'h0000, 3, 1, 20, 1, 1, 0);
        run_one("R1 eq not taken",     enc_eq(5'd3, 5'd7),         16'h0000, 3, 1, 7,  0, 0, 0);
        run_one("R2 clr taken jmp",    enc_rbit(0, 5'd7, 3'd0),    16'h940C, 7, 0, 0,  2, 1, 0);
        run_one("R2 set taken lds",    enc_rbit(1, 5'd7, 3'd1),    16'h9010, 7, 0, 0,  2, 1, 0);
        run_one("R2 set not taken",    enc_rbit(1, 5'd7, 3'd7),    16'h940C, 7, 0, 0,  0, 0, 0);
        run_one("R2 clr not taken",    enc_rbit(0, 5'd7, 3'd1),    16'h940C, 7, 0, 0,  0, 0, 0);
        run_one("R3 io clr call",      enc_io(0, 5'd5, 3'd3),      16'h940F, 8'h25, 0, 0, 2, 1, 0);
        run_one("R3 io set sts",       enc_io(1, 5'd5, 3'd7),      16'h9200, 8'h25, 0, 0, 2, 1, 0);
        run_one("R3 io port31 R4 1w",  enc_io(1, 5'd31, 3'd6),     16'h9408, 8'h3F, 0, 0, 1, 1, 0);
        run_one("R4 near miss 1w",     enc_rbit(0, 5'd7, 3'd2),    16'h9001, 7, 0, 0,  1, 1, 0);
        run_one("R6 not taken bad",    enc_io(0, 5'd5, 3'd0),      16'hFFFF, 8'h25, 0, 0, 0, 0, 0);
        run_one("R6 taken bad",        enc_rbit(0, 5'd7, 3'd0),    16'hFFFF, 7, 0, 0,  0, 0, 1);
        t_non_skip_r8();
        t_back_to_back_r7();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule